// File: doc/BRIEF.md
# Phase-Coherent Profile Oscillator

This block is one numerically controlled oscillator that produces a complex tone, 16-bit signed I and Q, at one sample per clock. Its phase is not built up by adding a step to a phase register every sample. Each sample's phase is computed directly from a free-running time counter that starts at reset: the phase is the frequency word times the counter value, plus the phase offset placed in the upper bits. A given frequency and offset therefore always lead to the same phase at the same instant, whichever profiles were active before.

The oscillator holds a table of 32 profiles. Each profile has a 32-bit frequency word, a 16-bit phase offset and a 16-bit unsigned amplitude. A slow write port fills the table one field at a time. A trigger strobe, together with a profile index, copies one table entry into an active-profile register. That register feeds the phase computation, a pipelined CORDIC rotator and an amplitude multiplier. The profile chosen by a trigger takes effect on a fixed sample, and that sample reaches the outputs a fixed number of cycles later. A surrounding pulse shaper can align its envelope to that sample.

Top module: `pco_osc`

## Requirements
- R1: While reset is asserted, and after it, before any write, I and Q are 0. Every profile entry resets to all zeros, so triggering any profile that has never been written gives 0 on both outputs.
- R2: The time counter is 0 during reset and increases by one on every clock edge after reset. The sample computed in the cycle in which the counter holds t has phase (F*t + P*2^16) mod 2^32, where one full turn is 2^32.
- R3: The phase after a profile change depends only on the new profile's frequency, its offset and the absolute time. Phase left by earlier profiles does not carry over.
- R4: A write with wr_en_i=1 updates one field of the entry wr_idx_i. The field codes are 0 for frequency (all 32 data bits), 1 for phase offset (data bits 15:0) and 2 for amplitude (data bits 15:0). Code 3 changes nothing.
- R5: Writes to the table never change the active profile, even a write to the entry that is currently active. If a write and a trigger hit the same entry on the same edge, the trigger captures the contents the entry held before that write.
- R6: When trig_i is high on a clock edge, the entry sel_i becomes active for the sample whose counter value is the one reached on that edge. That sample appears on I and Q exactly 20 clock edges later.
- R7: I is within 6 LSB of 32767*cos(phase)*A/65536, and Q is within 6 LSB of 32767*sin(phase)*A/65536, where A is the unsigned amplitude and the phase is taken in turns.
- R8: Neither output ever takes the value -32768, so the output range is symmetric.
- R9: An amplitude of 0 gives exactly 0 on I and Q, whatever the frequency and phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Profile table write strobe |
| wr_idx_i | input | 5 | Profile entry to write |
| wr_fld_i | input | 2 | Field code: 0 frequency, 1 phase, 2 amplitude, 3 none |
| wr_data_i | input | 32 | Write data |
| trig_i | input | 1 | Trigger: make entry sel_i active |
| sel_i | input | 5 | Profile index sampled with trig_i |
| i_o | output | 16 | In-phase sample, signed |
| q_o | output | 16 | Quadrature sample, signed |

## Verification
The assertions take for granted that every input is synchronous to the clock and free of unknown values from the first edge after reset. They also assume that the 20-cycle history they look back over starts at reset, with the pipeline holding zero amplitude. The stimulus changes every input only at the falling edge, drops each strobe one nanosecond after the rising edge it was sampled on, and releases reset away from any edge. Writes land both on idle entries and on the active entry. A write and a trigger are issued together once, and field code 3 is exercised.

// File: rtl/pco_pkg.sv
package pco_pkg;
  localparam int FREQ_W   = 32;
  localparam int POFS_W   = 16;
  localparam int AMP_W    = 16;
  localparam int OUT_W    = 16;
  localparam int N_PROF   = 32;
  localparam int IDX_W    = $clog2(N_PROF);
  localparam int FLD_W    = 2;
  localparam int CORDIC_W = 20;
  localparam int CORDIC_N = 16;
  localparam int GUARD_W  = CORDIC_W - OUT_W - 2;
  // phase stage + fold + rotations + round + scale
  localparam int LATENCY  = CORDIC_N + 4;

  typedef enum logic [FLD_W-1:0] {
    FLD_FREQ  = 2'd0,
    FLD_PHASE = 2'd1,
    FLD_AMP   = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic [POFS_W-1:0] pofs;
    logic [AMP_W-1:0]  amp;
  } prof_t;
endpackage

// File: rtl/pco_profile_table.sv
module pco_profile_table
  import pco_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [FLD_W-1:0]     wr_fld_i,
  input  logic [FREQ_W-1:0]    wr_data_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output prof_t                rd_prof_o
);
  prof_t ent_q [N_PROF];

  for (genvar g = 0; g < N_PROF; g++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= '0;
      end else if (hit) begin
        case (fld_e'(wr_fld_i))
          FLD_FREQ:  ent_q[g].freq <= wr_data_i;
          FLD_PHASE: ent_q[g].pofs <= wr_data_i[POFS_W-1:0];
          FLD_AMP:   ent_q[g].amp  <= wr_data_i[AMP_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  assign rd_prof_o = ent_q[rd_idx_i];
endmodule

// File: rtl/pco_phase_gen.sv
module pco_phase_gen
  import pco_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  prof_t               prof_i,
  output logic [FREQ_W-1:0]   time_o,
  output logic [CORDIC_W-1:0] phase_o,
  output logic [AMP_W-1:0]    amp_o
);
  logic [FREQ_W-1:0] time_q;
  logic [FREQ_W-1:0] ph_full;
  logic [FREQ_W-CORDIC_W-1:0] unused_ph_lo;

  // absolute phase: no dependence on earlier phase values
  assign ph_full = prof_i.freq * time_q + {prof_i.pofs, {(FREQ_W-POFS_W){1'b0}}};
  assign unused_ph_lo = ph_full[FREQ_W-CORDIC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q  <= '0;
      phase_o <= '0;
      amp_o   <= '0;
    end else begin
      time_q  <= time_q + FREQ_W'(1);
      phase_o <= ph_full[FREQ_W-1 -: CORDIC_W];
      amp_o   <= prof_i.amp;
    end
  end

  assign time_o = time_q;
endmodule

// File: rtl/pco_cordic.sv
module pco_cordic
  import pco_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CORDIC_W-1:0]     phase_i,
  input  logic [AMP_W-1:0]        amp_i,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic [AMP_W-1:0]        amp_o
);
  // start vector: (2^(OUT_W+1)-1)/gain, gain ~1.64676
  localparam logic signed [CORDIC_W-1:0] X_INIT = CORDIC_W'(79593);
  localparam logic signed [OUT_W-1:0]    O_MAX  = {1'b0, {(OUT_W-1){1'b1}}};

  function automatic logic signed [CORDIC_W-1:0] atan_step(input int i);
    case (i)
      0:  atan_step = CORDIC_W'(131072);
      1:  atan_step = CORDIC_W'(77376);
      2:  atan_step = CORDIC_W'(40884);
      3:  atan_step = CORDIC_W'(20753);
      4:  atan_step = CORDIC_W'(10417);
      5:  atan_step = CORDIC_W'(5213);
      6:  atan_step = CORDIC_W'(2607);
      7:  atan_step = CORDIC_W'(1304);
      8:  atan_step = CORDIC_W'(652);
      9:  atan_step = CORDIC_W'(326);
      10: atan_step = CORDIC_W'(163);
      11: atan_step = CORDIC_W'(81);
      12: atan_step = CORDIC_W'(41);
      13: atan_step = CORDIC_W'(20);
      14: atan_step = CORDIC_W'(10);
      15: atan_step = CORDIC_W'(5);
      default: atan_step = '0;
    endcase
  endfunction

  function automatic logic signed [OUT_W-1:0] sat_out(input logic signed [CORDIC_W-1:0] v,
                                                      input logic neg);
    logic signed [OUT_W-1:0] s;
    if (v > CORDIC_W'(O_MAX))       s = O_MAX;
    else if (v < -CORDIC_W'(O_MAX)) s = -O_MAX;
    else                            s = v[OUT_W-1:0];
    sat_out = neg ? -s : s;
  endfunction

  logic signed [CORDIC_W-1:0] x_q [CORDIC_N+1];
  logic signed [CORDIC_W-1:0] y_q [CORDIC_N+1];
  logic signed [CORDIC_W-1:0] z_q [CORDIC_N+1];
  logic                       neg_q [CORDIC_N+1];
  logic [AMP_W-1:0]           amp_q [CORDIC_N+1];
  logic                       unused_z;

  assign unused_z = ^z_q[CORDIC_N];

  // fold angles beyond a quarter turn by a half turn, flip sign at the end
  logic fold;
  assign fold = phase_i[CORDIC_W-1] ^ phase_i[CORDIC_W-2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q[0]   <= '0;
      y_q[0]   <= '0;
      z_q[0]   <= '0;
      neg_q[0] <= 1'b0;
      amp_q[0] <= '0;
    end else begin
      x_q[0]   <= X_INIT;
      y_q[0]   <= '0;
      z_q[0]   <= {phase_i[CORDIC_W-1] ^ fold, phase_i[CORDIC_W-2:0]};
      neg_q[0] <= fold;
      amp_q[0] <= amp_i;
    end
  end

  for (genvar i = 0; i < CORDIC_N; i++) begin : g_stage
    logic signed [CORDIC_W-1:0] xs, ys;
    logic                       dir;
    assign xs  = x_q[i] >>> i;
    assign ys  = y_q[i] >>> i;
    assign dir = z_q[i][CORDIC_W-1];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        x_q[i+1]   <= '0;
        y_q[i+1]   <= '0;
        z_q[i+1]   <= '0;
        neg_q[i+1] <= 1'b0;
        amp_q[i+1] <= '0;
      end else begin
        x_q[i+1]   <= dir ? x_q[i] + ys : x_q[i] - ys;
        y_q[i+1]   <= dir ? y_q[i] - xs : y_q[i] + xs;
        z_q[i+1]   <= dir ? z_q[i] + atan_step(i) : z_q[i] - atan_step(i);
        neg_q[i+1] <= neg_q[i];
        amp_q[i+1] <= amp_q[i];
      end
    end
  end

  logic signed [CORDIC_W-1:0] x_rnd, y_rnd;
  assign x_rnd = (x_q[CORDIC_N] + CORDIC_W'(2)) >>> 2;
  assign y_rnd = (y_q[CORDIC_N] + CORDIC_W'(2)) >>> 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_o <= '0;
      sin_o <= '0;
      amp_o <= '0;
    end else begin
      cos_o <= sat_out(x_rnd, neg_q[CORDIC_N]);
      sin_o <= sat_out(y_rnd, neg_q[CORDIC_N]);
      amp_o <= amp_q[CORDIC_N];
    end
  end
endmodule

// File: rtl/pco_scale.sv
module pco_scale
  import pco_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [OUT_W-1:0] cos_i,
  input  logic signed [OUT_W-1:0] sin_i,
  input  logic [AMP_W-1:0]        amp_i,
  output logic signed [OUT_W-1:0] i_o,
  output logic signed [OUT_W-1:0] q_o
);
  localparam int PW = OUT_W + AMP_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (AMP_W - 1);

  logic signed [AMP_W:0]  amp_s;
  logic signed [PW-1:0]   pi, pq, ri, rq;
  logic [2*(PW-OUT_W)-1:0] unused_rnd;

  assign amp_s = {1'b0, amp_i};
  assign pi = cos_i * amp_s;
  assign pq = sin_i * amp_s;
  // round half up, then drop AMP_W fraction bits
  assign ri = pi + HALF;
  assign rq = pq + HALF;
  assign unused_rnd = {ri[PW-1], ri[AMP_W-1:0], rq[PW-1], rq[AMP_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_o <= '0;
      q_o <= '0;
    end else begin
      i_o <= ri[AMP_W +: OUT_W];
      q_o <= rq[AMP_W +: OUT_W];
    end
  end
endmodule

// File: rtl/pco_osc.sv
module pco_osc
  import pco_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [FLD_W-1:0]        wr_fld_i,
  input  logic [FREQ_W-1:0]       wr_data_i,
  input  logic                    trig_i,
  input  logic [IDX_W-1:0]        sel_i,
  output logic signed [OUT_W-1:0] i_o,
  output logic signed [OUT_W-1:0] q_o
);
  prof_t                   rd_prof, act_q;
  logic [FREQ_W-1:0]       t_q;
  logic [CORDIC_W-1:0]     phase;
  logic [AMP_W-1:0]        amp_ph, amp_cs;
  logic signed [OUT_W-1:0] cos_v, sin_v;

  pco_profile_table i_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_fld_i  (wr_fld_i),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (sel_i),
    .rd_prof_o (rd_prof)
  );

  // active copy: table writes never reach the running tone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (trig_i) act_q <= rd_prof;
  end

  pco_phase_gen i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prof_i  (act_q),
    .time_o  (t_q),
    .phase_o (phase),
    .amp_o   (amp_ph)
  );

  pco_cordic i_cordic (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .amp_i   (amp_ph),
    .cos_o   (cos_v),
    .sin_o   (sin_v),
    .amp_o   (amp_cs)
  );

  pco_scale i_scale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cos_i  (cos_v),
    .sin_i  (sin_v),
    .amp_i  (amp_cs),
    .i_o    (i_o),
    .q_o    (q_o)
  );
endmodule

// File: rtl/pco_osc_chk.sv
module pco_osc_chk
  import pco_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    trig_i,
  input prof_t                   rd_prof,
  input prof_t                   act_q,
  input logic [FREQ_W-1:0]       t_q,
  input logic signed [OUT_W-1:0] i_o,
  input logic signed [OUT_W-1:0] q_o
);
  logic [5:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   age_q <= '0;
    else if (age_q < 6'(LATENCY))  age_q <= age_q + 6'd1;
  end

  a_r2_time_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> t_q == $past(t_q) + FREQ_W'(1));

  a_r6_trig_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> act_q == $past(rd_prof));

  a_r5_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> $stable(act_q));

  a_r8_symmetric: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_o != {1'b1, {(OUT_W-1){1'b0}}} && q_o != {1'b1, {(OUT_W-1){1'b0}}});

  a_r9_zero_amp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 6'(LATENCY) && $past(act_q.amp, 20) == '0) |-> (i_o == '0 && q_o == '0));
endmodule

bind pco_osc pco_osc_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .trig_i  (trig_i),
  .rd_prof (rd_prof),
  .act_q   (act_q),
  .t_q     (t_q),
  .i_o     (i_o),
  .q_o     (q_o)
);

// File: tb/test_pco_osc.sv
module test_pco_osc;
  localparam int LAT = 20;
  localparam int TOL = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [1:0]  wr_fld = '0;
  logic [31:0] wr_data = '0;
  logic        trig = 1'b0;
  logic [4:0]  sel = '0;
  logic signed [15:0] i_o, q_o;

  always #4 clk = ~clk;

  pco_osc i_pco_osc (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_fld_i(wr_fld), .wr_data_i(wr_data), .trig_i(trig), .sel_i(sel),
    .i_o(i_o), .q_o(q_o)
  );

  typedef struct { int ei; int eq; bit exact; string tag; int t; } exp_t;
  exp_t sb[$];

  logic [31:0] mf [32];
  logic [15:0] mp [32];
  logic [15:0] ma [32];
  logic [31:0] af = '0;
  logic [15:0] ap = '0, aa = '0;
  string cur_tag = "R1";
  int n_vec = 0, n_bad = 0, n_smp = 0;
  bit done = 1'b0;

  function automatic void calc(input logic [31:0] f, input logic [15:0] p,
                               input logic [15:0] a, input int t,
                               output int ei, output int eq);
    logic [31:0] ph;
    real ang, mag;
    ph  = f * t + {p, 16'h0000};
    ang = 6.283185307179586 * $itor(ph) / 4294967296.0;
    mag = 32767.0 * $itor({16'h0000, a}) / 65536.0;
    ei  = $rtoi($floor(mag * $cos(ang) + 0.5));
    eq  = $rtoi($floor(mag * $sin(ang) + 0.5));
  endfunction

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  // driver side: push expected sample for the current counter value
  // monitor side: pop the one that is now LAT edges old and compare
  always @(negedge clk) begin
    exp_t it, e;
    int ai, aq, tol;
    if (rst_n && !done) begin
      n_smp++;
      it.t = n_smp;
      calc(af, ap, aa, n_smp, it.ei, it.eq);
      it.exact = (aa == 16'h0);
      it.tag = cur_tag;
      sb.push_back(it);
      if (sb.size() > LAT) begin
        e = sb.pop_front();
        ai = i_o; aq = q_o;
        tol = e.exact ? 0 : TOL;
        n_vec++;
        if (iabs(ai - e.ei) > tol || iabs(aq - e.eq) > tol) begin
          n_bad++;
          $display("FAIL %s (R7 tol %0d) t=%0d I=%0d exp %0d Q=%0d exp %0d",
                   e.tag, tol, e.t, ai, e.ei, aq, e.eq);
        end
        if (ai == -32768 || aq == -32768) begin
          n_bad++;
          $display("FAIL R8 t=%0d I=%0d Q=%0d exp not -32768", e.t, ai, aq);
        end
      end
    end
  end

  task automatic wr(input int idx, input int fld, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_fld = 2'(fld); wr_data = d;
    @(posedge clk);
    case (fld)
      0: mf[idx] = d;
      1: mp[idx] = d[15:0];
      2: ma[idx] = d[15:0];
      default: ;
    endcase
    #1 wr_en = 1'b0;
  endtask

  task automatic fire(input int idx);
    @(negedge clk);
    trig = 1'b1; sel = 5'(idx);
    @(posedge clk);
    af = mf[idx]; ap = mp[idx]; aa = ma[idx];
    #1 trig = 1'b0;
  endtask

  task automatic wr_fire(input int idx, input int fld, input logic [31:0] d);
    @(negedge clk);
    trig = 1'b1; sel = 5'(idx);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_fld = 2'(fld); wr_data = d;
    @(posedge clk);
    af = mf[idx]; ap = mp[idx]; aa = ma[idx];
    if (fld == 2) ma[idx] = d[15:0];
    #1 trig = 1'b0; wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_reset();
    n_vec++;
    if (i_o !== 16'sd0 || q_o !== 16'sd0) begin
      n_bad++;
      $display("FAIL R1 reset I=%0d Q=%0d exp 0 0", i_o, q_o);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) begin mf[k] = '0; mp[k] = '0; ma[k] = '0; end
    #20 chk_reset();
    #13 chk_reset();
    @(negedge clk); #1 rst_n = 1'b1;

    cur_tag = "R1"; idle(30);

    cur_tag = "R4";                  // writes while profile 0 is active: outputs stay 0 (R5)
    wr(1, 0, 32'h0100_0000); wr(1, 2, 32'h0000_FFFF);
    wr(2, 0, 32'h0A3D_70A4); wr(2, 1, 32'h0000_4000); wr(2, 2, 32'h0000_8000);
    wr(3, 1, 32'h0000_2000); wr(3, 2, 32'h0000_C000);
    wr(1, 3, 32'hDEAD_BEEF);         // field code 3 ignored
    idle(25);

    cur_tag = "R6"; fire(1); idle(60);
    cur_tag = "R2"; idle(40);
    cur_tag = "R3"; fire(2); idle(40);
    cur_tag = "R3"; fire(1); idle(40);
    cur_tag = "R3"; fire(3); idle(30);
    cur_tag = "R4"; wr(1, 3, 32'h1234_5678); fire(1); idle(30);

    cur_tag = "R5"; wr(1, 0, 32'h0400_0000); wr(1, 2, 32'h0000_1000); idle(30);
    cur_tag = "R5"; fire(1); idle(30);
    cur_tag = "R5"; wr_fire(2, 2, 32'h0000_1000); idle(30);
    cur_tag = "R5"; fire(2); idle(30);

    cur_tag = "R7";
    wr(4, 2, 32'h0000_FFFF);
    foreach (mp[k]) if (k < 7) begin
      logic [15:0] pv;
      case (k)
        0: pv = 16'h0000; 1: pv = 16'h4000; 2: pv = 16'h8000;
        3: pv = 16'hC000; 4: pv = 16'h2000; 5: pv = 16'hE000;
        default: pv = 16'h3FFF;
      endcase
      wr(4, 1, {16'h0, pv}); fire(4); idle(25);
    end
    wr(6, 0, 32'h8000_0000); wr(6, 2, 32'h0000_FFFF); fire(6); idle(30);
    wr(9, 0, 32'h1555_5555); wr(9, 1, 32'h0000_9000); wr(9, 2, 32'h0000_7FFF);
    fire(9); idle(40);

    cur_tag = "R9"; fire(0); idle(30);
    wr(8, 0, 32'h0777_7777); wr(8, 1, 32'h0000_3000); fire(8); idle(30);
    cur_tag = "R1"; fire(7); idle(30);
    idle(LAT + 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule